// File: doc/BRIEF.md
# Bus-Mapped Programmable Pin Cell

This block is one general-purpose pin hanging off an ISA-style I/O bus. A single 11-bit address, supplied on its own input, names the pin on the bus. A bus cycle is taken as aimed at the pin when AEN is low and the bus address equals that match address. A configuration byte picks the pin's job. The byte is written and read back through an index/data register pair, and only while the configuration-enable input is high.

The mode field in bits 7:5 of the configuration byte picks one of five jobs. In mode 000 the pin is idle and tri-stated. In mode 001 it is an output that is loaded by bus writes. In mode 010 it is an input that is read over bus data bit 0. In mode 011 it is bidirectional. Any value 1xx makes it an address-decoded chip select, and bit 4 of the byte sets that chip select's polarity.

Top module: `isa_gpio_pin`

## Requirements
- R1: After reset the configuration byte and the index register are 00h, the held output bit is 0, and both pinOe and busD0Oe are low.
- R2: A cfgIndexWr pulse loads cfgWrData into the index register only while cfgEnable is high. A cfgDataWr pulse loads the configuration byte only while cfgEnable is high and the index, as it stood before that edge, equals 14h. cfgRdData shows the byte when cfgEnable is high and the index is 14h, and shows 00h otherwise.
- R3: With mode bits 7:5 = 000, pinOe and busD0Oe stay low whatever bus cycles occur.
- R4: With mode 001 the pin is driven (pinOe high) with the held bit. Clock edges where AEN is low, iowN is low and the address matches form a qualified write, and each one samples busD0In. The last sample is loaded into the held bit at the first edge after the qualified write ends, so pinOut changes one cycle after the strobe is released. The held bit is then kept until the next qualified write.
- R5: With mode 010 the pin is not driven. During a cycle with AEN low, iorN low and a matching address, busD0Oe is high and busD0Out follows pinIn in the same cycle.
- R6: With mode 011 the pin is driven continuously with the held bit, as in R4. Qualified reads drive busD0Out with the actual pinIn level, as in R5.
- R7: With mode bit 7 set, pinOe is high. The select is active while AEN is low, the address matches, and iorN or iowN is low. pinOut is then 1 if bit 4 is 1 and 0 if bit 4 is 0; when the select is inactive pinOut is the opposite level.
- R8: A bus cycle with AEN high, or with an address other than matchAddr, loads nothing, enables no bus driver and activates no chip select.
- R9: busD0Oe is low outside qualified reads in modes 010 and 011. Bus writes in modes 000, 010 and 1xx leave the held bit unchanged, and this is visible once mode 001 is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Configuration access window open |
| cfgIndexWr | input | 1 | Write strobe for the index register |
| cfgDataWr | input | 1 | Write strobe for the data register |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration byte read-back |
| matchAddr | input | 11 | I/O address assigned to the pin |
| busAddr | input | 11 | Bus I/O address |
| aen | input | 1 | Address enable; high means a DMA cycle, which is ignored |
| iorN | input | 1 | Bus I/O read strobe, active low |
| iowN | input | 1 | Bus I/O write strobe, active low |
| busD0In | input | 1 | Bus data bit 0, write direction |
| busD0Out | output | 1 | Bus data bit 0, read direction |
| busD0Oe | output | 1 | Drive enable for bus data bit 0 |
| pinIn | input | 1 | Level sensed at the pin |
| pinOut | output | 1 | Level driven onto the pin |
| pinOe | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a bus write that arrives while the pin is in a mode that must ignore it. That write could still corrupt the held bit, and the corruption shows nowhere until output mode returns. The stimulus therefore writes the inverse of the held bit in input, idle and chip-select modes. It then switches back to mode 001 and compares the driven level. A further randomized phase changes the mode in the middle of bus strobes. This covers a qualified write that ends because the mode changed rather than because iowN was released.

// File: rtl/isa_gpio_pkg.sv
package isa_gpio_pkg;
  localparam int CFG_W    = 8;
  localparam int IDX_W    = 8;
  localparam int MODE_LO  = 5;
  localparam int MODE_HI  = 7;
  localparam int POL_BIT  = 4;
  localparam int MODE_W   = MODE_HI - MODE_LO + 1;

  localparam logic [MODE_W-1:0] MODE_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_OUT   = 3'b001;
  localparam logic [MODE_W-1:0] MODE_IN    = 3'b010;
  localparam logic [MODE_W-1:0] MODE_BIDIR = 3'b011;

  typedef struct packed {
    logic wrQual;   // qualified write in a mode that latches
    logic rdQual;   // qualified read in a mode that reports the pin
    logic csHit;    // decoded select cycle
    logic drvLatch; // pin drives the held bit
    logic drvCs;    // pin drives the select level
    logic csHigh;   // select polarity
  } gpioStrobes_t;
endpackage

// File: rtl/isa_gpio_addr_dec.sv
module isa_gpio_addr_dec #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] matchAddr,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  output logic              wrHit,
  output logic              rdHit,
  output logic              selHit
);
  logic cycleHit;

  // A cycle is aimed at this pin only when it is not a DMA cycle and the address matches
  assign cycleHit = !aen && (busAddr == matchAddr);
  assign wrHit    = cycleHit && !iowN;
  assign rdHit    = cycleHit && !iorN;
  assign selHit   = cycleHit && (!iorN || !iowN);
endmodule

// File: rtl/isa_gpio_ctrl.sv
module isa_gpio_ctrl
  import isa_gpio_pkg::*;
#(
  parameter logic [IDX_W-1:0] CFG_INDEX = 8'h14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgIndexWr,
  input  logic             cfgDataWr,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic [CFG_W-1:0] cfgByte,
  input  logic             wrHit,
  input  logic             rdHit,
  input  logic             selHit,
  output gpioStrobes_t     strobes
);
  logic [IDX_W-1:0]  cfgIndexQ;
  logic [CFG_W-1:0]  cfgByteQ;
  logic              idxMatch;
  logic [MODE_W-1:0] mode;
  logic              isOut;
  logic              isIn;
  logic              isCs;

  assign idxMatch = (cfgIndexQ == CFG_INDEX);

  // The index register and the byte both take their writes from the value before the edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgIndexQ <= '0;
      cfgByteQ  <= '0;
    end else begin
      if (cfgEnable && cfgIndexWr)
        cfgIndexQ <= cfgWrData[IDX_W-1:0];
      if (cfgEnable && cfgDataWr && idxMatch)
        cfgByteQ <= cfgWrData;
    end
  end

  assign cfgByte   = cfgByteQ;
  assign cfgRdData = (cfgEnable && idxMatch) ? cfgByteQ : '0;

  assign mode  = cfgByteQ[MODE_HI:MODE_LO];
  assign isCs  = mode[MODE_W-1];
  assign isOut = (mode == MODE_OUT) || (mode == MODE_BIDIR);
  assign isIn  = (mode == MODE_IN)  || (mode == MODE_BIDIR);

  always_comb begin
    strobes          = '0;
    strobes.wrQual   = wrHit && isOut;
    strobes.rdQual   = rdHit && isIn;
    strobes.csHit    = selHit;
    strobes.drvLatch = isOut;
    strobes.drvCs    = isCs;
    strobes.csHigh   = cfgByteQ[POL_BIT];
  end
endmodule

// File: rtl/isa_gpio_dp.sv
module isa_gpio_dp
  import isa_gpio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  gpioStrobes_t strobes,
  input  logic         busD0In,
  input  logic         pinIn,
  output logic         busD0Out,
  output logic         busD0Oe,
  output logic         pinOut,
  output logic         pinOe
);
  logic wrQualQ;
  logic dataQ;
  logic heldQ;

  // The bit is sampled on every qualified cycle and committed when the qualified strobe ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQualQ <= 1'b0;
      dataQ   <= 1'b0;
      heldQ   <= 1'b0;
    end else begin
      wrQualQ <= strobes.wrQual;
      if (strobes.wrQual)
        dataQ <= busD0In;
      if (wrQualQ && !strobes.wrQual)
        heldQ <= dataQ;
    end
  end

  always_comb begin
    pinOe  = strobes.drvCs || strobes.drvLatch;
    pinOut = 1'b0;
    if (strobes.drvCs)
      pinOut = strobes.csHigh ? strobes.csHit : !strobes.csHit;
    else if (strobes.drvLatch)
      pinOut = heldQ;
  end

  assign busD0Oe  = strobes.rdQual;
  assign busD0Out = strobes.rdQual ? pinIn : 1'b0;
endmodule

// File: rtl/isa_gpio_pin.sv
module isa_gpio_pin
  import isa_gpio_pkg::*;
#(
  parameter int               ADDR_W    = 11,
  parameter logic [IDX_W-1:0] CFG_INDEX = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgIndexWr,
  input  logic              cfgDataWr,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic [ADDR_W-1:0] matchAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              busD0In,
  output logic              busD0Out,
  output logic              busD0Oe,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe
);
  logic         wrHit;
  logic         rdHit;
  logic         selHit;
  logic [CFG_W-1:0] cfgByte;
  gpioStrobes_t strobes;

  isa_gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .busAddr(busAddr), .matchAddr(matchAddr), .aen(aen),
    .iorN(iorN), .iowN(iowN),
    .wrHit(wrHit), .rdHit(rdHit), .selHit(selHit)
  );

  isa_gpio_ctrl #(.CFG_INDEX(CFG_INDEX)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgIndexWr(cfgIndexWr), .cfgDataWr(cfgDataWr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cfgByte(cfgByte),
    .wrHit(wrHit), .rdHit(rdHit), .selHit(selHit),
    .strobes(strobes)
  );

  isa_gpio_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busD0In(busD0In), .pinIn(pinIn),
    .busD0Out(busD0Out), .busD0Oe(busD0Oe),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/isa_gpio_pin_chk.sv
module isa_gpio_pin_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        cfgByte,
  input logic [ADDR_W-1:0] matchAddr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              aen,
  input logic              iorN,
  input logic              iowN,
  input logic              busD0Out,
  input logic              busD0Oe,
  input logic              pinIn,
  input logic              pinOut,
  input logic              pinOe
);
  logic selNow;
  assign selNow = !aen && (busAddr == matchAddr) && (!iorN || !iowN);

  // R8
  dma_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> !busD0Oe);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[7:5] == 3'b000) |-> (!pinOe && !busD0Oe));

  // R7
  cs_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgByte[7] |-> (pinOe && (pinOut == (cfgByte[4] ? selNow : !selNow))));

  // R5
  rd_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    busD0Oe |-> (busD0Out == pinIn && !iorN));

  // R6
  bidir_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[7:5] == 3'b011) |-> pinOe);

  // R9
  rd_only_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    busD0Oe |-> (cfgByte[7:5] == 3'b010 || cfgByte[7:5] == 3'b011));
endmodule

bind isa_gpio_pin isa_gpio_pin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .matchAddr(matchAddr),
  .busAddr(busAddr), .aen(aen), .iorN(iorN), .iowN(iowN),
  .busD0Out(busD0Out), .busD0Oe(busD0Oe), .pinIn(pinIn),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/isa_gpio_pin_bench.sv
module isa_gpio_pin_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgIndexWr = 1'b0, cfgDataWr = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [10:0] matchAddr = 11'h2A5;
  logic [10:0] busAddr = '0;
  logic        aen = 1'b1, iorN = 1'b1, iowN = 1'b1, busD0In = 1'b0;
  logic        busD0Out, busD0Oe;
  logic        pinIn = 1'b0;
  logic        pinOut, pinOe;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural reference state
  int mCfg = 0, mIdx = 0, mHeld = 0, mWrQ = 0, mWrD = 0;

  always #2 clk = ~clk;

  isa_gpio_pin u_isa_gpio_pin (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgIndexWr(cfgIndexWr),
    .cfgDataWr(cfgDataWr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .matchAddr(matchAddr), .busAddr(busAddr), .aen(aen), .iorN(iorN),
    .iowN(iowN), .busD0In(busD0In), .busD0Out(busD0Out), .busD0Oe(busD0Oe),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic int modeOf();
    return (mCfg >> 5) & 7;
  endfunction

  function automatic int hitNow();
    return (!aen && busAddr == matchAddr) ? 1 : 0;
  endfunction

  // reference update at each edge, from the inputs held during the cycle before it
  always @(posedge clk) begin
    int m, qual;
    if (!rstN) begin
      mCfg = 0; mIdx = 0; mHeld = 0; mWrQ = 0; mWrD = 0;
    end else begin
      m = modeOf();
      qual = (hitNow() && !iowN && (m == 1 || m == 3)) ? 1 : 0;
      if (mWrQ && !qual) mHeld = mWrD;
      if (qual) mWrD = busD0In;
      mWrQ = qual;
      if (cfgEnable && cfgDataWr && mIdx == 'h14) mCfg = cfgWrData;
      if (cfgEnable && cfgIndexWr) mIdx = cfgWrData;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // comparison every clock, mid-cycle
  always @(negedge clk) begin
    int m, eOe, eOut, eBusOe, sel, eRd;
    if (!done) begin
      m = modeOf();
      eOe = 0; eOut = 0;
      if (m == 1 || m == 3) begin eOe = 1; eOut = mHeld; end
      else if (m >= 4) begin
        sel = (hitNow() && (!iorN || !iowN)) ? 1 : 0;
        eOe = 1;
        eOut = ((mCfg >> 4) & 1) ? sel : (sel ? 0 : 1);
      end
      eBusOe = (hitNow() && !iorN && (m == 2 || m == 3)) ? 1 : 0;
      eRd = (cfgEnable && mIdx == 'h14) ? mCfg : 0;
      chk("pinOe", int'(pinOe), eOe);
      if (eOe) chk("pinOut", int'(pinOut), eOut);
      chk("busD0Oe", int'(busD0Oe), eBusOe);
      if (eBusOe) chk("busD0Out", int'(busD0Out), int'(pinIn));
      chk("cfgRdData", int'(cfgRdData), eRd);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfgWr(int idx, int data, bit en = 1);
    cfgEnable = en; cfgIndexWr = 1; cfgWrData = 8'(idx); tick();
    cfgIndexWr = 0; cfgDataWr = 1; cfgWrData = 8'(data); tick();
    cfgDataWr = 0; tick();
  endtask

  task automatic busWr(logic [10:0] a, bit d, bit dma = 0);
    busAddr = a; aen = dma; busD0In = d; tick();
    iowN = 0; tick(2);
    iowN = 1; tick();
    aen = 1; tick();
  endtask

  task automatic busRd(logic [10:0] a, bit p, bit dma = 0);
    busAddr = a; aen = dma; pinIn = p; tick();
    iorN = 0; tick(2);
    pinIn = !p; tick();
    iorN = 1; tick();
    aen = 1; tick();
  endtask

  task automatic expectPin(bit v);
    #0;
    @(negedge clk);
    checks++;
    if (pinOut !== v || pinOe !== 1'b1) begin
      errors++;
      $display("FAIL %s held bit: actual %0b/%0b expected %0b/1", curReq, pinOut, pinOe, v);
    end
    tick();
  endtask

  initial begin
    curReq = "R1";
    tick(3);
    rstN = 1; tick(2);
    // R2: gated and wrong-index writes have no effect
    curReq = "R2";
    cfgWr('h14, 'h20, 0);
    cfgWr('h13, 'h20);
    cfgWr('h14, 'h00); cfgEnable = 1; tick(2); cfgEnable = 0;
    // R3: idle mode ignores matching cycles
    curReq = "R3";
    busWr(matchAddr, 1); busRd(matchAddr, 1);
    // R4: output mode
    curReq = "R4";
    cfgWr('h14, 'h20);
    busWr(matchAddr, 1); expectPin(1);
    busWr(matchAddr, 0); expectPin(0);
    busWr(matchAddr, 1); tick(5); expectPin(1);
    // R8: DMA and mismatched cycles
    curReq = "R8";
    busWr(matchAddr, 0, 1); expectPin(1);
    busWr(matchAddr ^ 11'h001, 0); busWr(matchAddr ^ 11'h400, 0); expectPin(1);
    // R5: input mode
    curReq = "R5";
    cfgWr('h14, 'h40);
    busRd(matchAddr, 1); busRd(matchAddr, 0);
    curReq = "R8";
    busRd(matchAddr, 1, 1); busRd(matchAddr ^ 11'h080, 1);
    // R9: writes in non-output modes leave the held bit alone
    curReq = "R9";
    busWr(matchAddr, 0);
    cfgWr('h14, 'h00); busWr(matchAddr, 0);
    cfgWr('h14, 'h90); busWr(matchAddr, 0);
    cfgWr('h14, 'h20); expectPin(1);
    // R6: bidirectional
    curReq = "R6";
    cfgWr('h14, 'h60);
    busWr(matchAddr, 0); expectPin(0);
    busRd(matchAddr, 1); busRd(matchAddr, 0);
    busWr(matchAddr, 1); expectPin(1);
    // R7: chip select, both polarities
    curReq = "R7";
    cfgWr('h14, 'h80);
    busRd(matchAddr, 0); busWr(matchAddr, 1); busWr(matchAddr ^ 11'h010, 1); busRd(matchAddr, 0, 1);
    cfgWr('h14, 'hF0);
    busRd(matchAddr, 0); busWr(matchAddr, 1); busWr(matchAddr ^ 11'h200, 1); busWr(matchAddr, 0, 1);
    // mixed random traffic, including mode changes under an active strobe
    curReq = "R4";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) begin
        cfgEnable = 1; cfgIndexWr = $urandom_range(0, 1); cfgDataWr = $urandom_range(0, 1);
        cfgWrData = ($urandom_range(0, 3) == 0) ? 8'h14 : 8'($urandom);
      end else begin
        cfgEnable = $urandom_range(0, 1); cfgIndexWr = 0; cfgDataWr = 0;
      end
      busAddr = ($urandom_range(0, 2) != 0) ? matchAddr : 11'($urandom);
      aen = ($urandom_range(0, 4) == 0);
      iorN = $urandom_range(0, 1); iowN = $urandom_range(0, 1);
      busD0In = $urandom_range(0, 1); pinIn = $urandom_range(0, 1);
      tick();
    end
    cfgEnable = 0; cfgIndexWr = 0; cfgDataWr = 0; iorN = 1; iowN = 1; aen = 1;
    tick(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL %s watchdog expired", curReq);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule